// File: doc/BRIEF.md
# PLL divider search engine

This block walks through the integer divider pairs (N, M) of a PLL whose oscillator runs at 2 × M × floor(clkin / N). A start pulse latches the input clock rate, the requested oscillator window, the hardware oscillator ceiling, the intermediate-frequency window and the largest allowed N and M. The engine then works out the loop bounds with truncating divisions and offers each pair to an outside judge as a candidate. The pair goes out together with its intermediate frequency and its oscillator frequency.

Candidates leave on a valid/ready stream. A candidate is transferred in the cycle where `cand_valid` and `cand_ready` are both high, and `cand_accept` is read in that cycle only. While the judge holds `cand_ready` low, the candidate stays on the outputs unchanged. When a candidate is accepted the search stops at once. When every candidate has been rejected the engine reports exhaustion. A reverse-order mode runs both loops from the top down.

All quotients come from one shared multi-cycle restoring divider. Each outer iteration therefore spends four divisions before its first candidate.

Top module: `pll_div_search`

## Requirements
- R1: After reset `busy`, `cand_valid`, `done` and `found` are all low.
- R2: In forward order N runs upward from max(ceil(clkin / fint_max), 1) in steps of 1. The value min(floor(clkin / fint_min), n_limit) is the bound and is never presented.
- R3: Every candidate carries `cand_fint` = floor(clkin / N) and `cand_osc` = 2 × M × `cand_fint`.
- R4: For each N, M is the inner loop. Its start is max(ceil(ceil(osc_min / fint) / 2), 1). Its bound, which is never presented, is the smallest of floor(osc_max / fint) / 2, floor(osc_hw_max / fint) / 2 and m_limit, with the halving truncating.
- R5: An `osc_max` of 0 places no upper limit on M from the requested window.
- R6: When `reverse_order` is 1, both loops begin at their bound value and step down by 1. They stop on reaching the start value, which is then never presented.
- R7: While `cand_valid` is high and `cand_ready` is low, `cand_valid` stays high and all candidate fields stay unchanged.
- R8: A transfer with `cand_accept` high ends the search. `done` pulses for one cycle in the next cycle with `found` high, and no further candidate appears.
- R9: After the last candidate is rejected, `done` pulses for one cycle with `found` low.
- R10: A loop whose start is at or past its bound in its direction of travel runs no iteration. An empty N range gives `done` with `found` low and no candidate. An empty M range skips that N.
- R11: `start` is ignored while `busy` is high. `found` keeps its value until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; sampled only while idle |
| clkin_rate | input | FW | Input clock rate |
| fint_min | input | FW | Lowest intermediate frequency |
| fint_max | input | FW | Highest intermediate frequency |
| osc_min | input | FW | Requested oscillator minimum |
| osc_max | input | FW | Requested oscillator maximum, 0 = unlimited |
| osc_hw_max | input | FW | Oscillator ceiling of the hardware |
| n_limit | input | FW | Largest N |
| m_limit | input | FW | Largest M |
| reverse_order | input | 1 | 1 = both loops run downward |
| busy | output | 1 | Search in progress |
| cand_valid | output | 1 | Candidate offered |
| cand_ready | input | 1 | Judge takes the candidate this cycle |
| cand_accept | input | 1 | Verdict, read together with cand_ready |
| cand_n | output | FW | Candidate N |
| cand_m | output | FW | Candidate M |
| cand_fint | output | FW | floor(clkin / N) |
| cand_osc | output | 2*FW+1 | 2 × M × cand_fint |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | Last search ended by acceptance |

## Verification
The checks on the candidate fields assume three things about the inputs. `clkin_rate` and the other configuration inputs stay constant from `start` until `done`. `fint_min`, `fint_max` and `osc_min` are non-zero. The configured limits keep floor(clkin / N) non-zero for every N in range. Under those conditions the intermediate-frequency assertion relates `cand_n`, `cand_fint` and the live `clkin_rate` port directly. The stimulus sets the configuration before each start pulse and leaves it untouched until the end-of-search pulse has been seen, and every scenario uses small non-zero rates. The judge's ready stalls vary with the candidate index, so the hold rule is exercised for stalls of zero, one and two cycles.

// File: rtl/pll_div_search_pkg.sv
`timescale 1ns/1ps
package pll_div_search_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIV_NLO,
    ST_DIV_NHI,
    ST_N_SETUP,
    ST_DIV_FINT,
    ST_DIV_MLO,
    ST_DIV_MHI,
    ST_DIV_MHW,
    ST_M_SETUP,
    ST_OFFER
  } srch_state_t;

endpackage

// File: rtl/pll_div_seq_divider.sv
`timescale 1ns/1ps
// Restoring divider: one quotient bit per cycle, result W cycles after go.
module pll_div_seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, rem_q, dvsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    trial;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    fits  = (trial >= {1'b0, dvsr_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvsr_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        quo_q  <= dividend_i;
        rem_q  <= '0;
        dvsr_q <= divisor_i;
        cnt_q  <= CW'(W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (fits) begin
          rem_q <= W'(trial - {1'b0, dvsr_q});
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign done_o = done_q;
endmodule

// File: rtl/pll_div_range_walk.sv
`timescale 1ns/1ps
// Orders one loop: picks first value, last (excluded) value and the step.
module pll_div_range_walk #(
  parameter int W = 32
) (
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] cur_i,
  input  logic         rev_i,
  output logic [W-1:0] first_o,
  output logic [W-1:0] next_o,
  output logic         empty_o,
  output logic         next_end_o
);
  logic [W-1:0] last;

  always_comb begin
    first_o    = rev_i ? hi_i : lo_i;
    last       = rev_i ? lo_i : hi_i;
    empty_o    = rev_i ? (hi_i <= lo_i) : (lo_i >= hi_i);
    next_o     = rev_i ? (cur_i - W'(1)) : (cur_i + W'(1));
    next_end_o = (next_o == last);
  end
endmodule

// File: rtl/pll_div_search.sv
`timescale 1ns/1ps
module pll_div_search
  import pll_div_search_pkg::*;
#(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] clkin_rate,
  input  logic [FW-1:0] fint_min,
  input  logic [FW-1:0] fint_max,
  input  logic [FW-1:0] osc_min,
  input  logic [FW-1:0] osc_max,
  input  logic [FW-1:0] osc_hw_max,
  input  logic [FW-1:0] n_limit,
  input  logic [FW-1:0] m_limit,
  input  logic          reverse_order,
  output logic          busy,
  output logic          cand_valid,
  input  logic          cand_ready,
  input  logic          cand_accept,
  output logic [FW-1:0] cand_n,
  output logic [FW-1:0] cand_m,
  output logic [FW-1:0] cand_fint,
  output logic [2*FW:0] cand_osc,
  output logic          done,
  output logic          found
);
  localparam int OW = 2 * FW + 1;

  srch_state_t state_q;

  logic [FW-1:0] c_clkin, c_fmin, c_fmax, c_omin, c_omax, c_ohw, c_nmax, c_mmax;
  logic          c_rev;
  logic [FW-1:0] n_lo, n_hi, n_cur, m_lo, m_hi, m_cur, fint_q;
  logic          div_go, done_q, found_q;

  logic [FW-1:0] div_a, div_b, div_q, div_r;
  logic          div_done;
  logic [FW:0]   ceil_w;
  logic [FW-1:0] ceil_n, half_up, q_half;

  logic [FW-1:0] n_first, n_next, m_first, m_next;
  logic          n_empty, n_next_end, m_empty, m_next_end;

  // operand selection follows the state that issued the division
  always_comb begin
    div_a = c_clkin;
    div_b = c_fmax;
    unique case (state_q)
      ST_DIV_NHI:  begin div_a = c_clkin; div_b = c_fmin; end
      ST_DIV_FINT: begin div_a = c_clkin; div_b = n_cur;  end
      ST_DIV_MLO:  begin div_a = c_omin;  div_b = fint_q; end
      ST_DIV_MHI:  begin div_a = (c_omax == '0) ? '1 : c_omax; div_b = fint_q; end
      ST_DIV_MHW:  begin div_a = c_ohw;   div_b = fint_q; end
      default:     begin div_a = c_clkin; div_b = c_fmax; end
    endcase
  end

  pll_div_seq_divider #(.W(FW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (div_go),
    .dividend_i (div_a),
    .divisor_i  (div_b),
    .quo_o      (div_q),
    .rem_o      (div_r),
    .done_o     (div_done)
  );

  always_comb begin
    ceil_w  = {1'b0, div_q} + {{FW{1'b0}}, (div_r != '0)};
    ceil_n  = ceil_w[FW] ? '1 : ceil_w[FW-1:0];
    half_up = ceil_w[FW:1] + {{(FW-1){1'b0}}, ceil_w[0]};
    q_half  = {1'b0, div_q[FW-1:1]};
  end

  pll_div_range_walk #(.W(FW)) u_nwalk (
    .lo_i (n_lo), .hi_i (n_hi), .cur_i (n_cur), .rev_i (c_rev),
    .first_o (n_first), .next_o (n_next), .empty_o (n_empty), .next_end_o (n_next_end)
  );

  pll_div_range_walk #(.W(FW)) u_mwalk (
    .lo_i (m_lo), .hi_i (m_hi), .cur_i (m_cur), .rev_i (c_rev),
    .first_o (m_first), .next_o (m_next), .empty_o (m_empty), .next_end_o (m_next_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      c_clkin <= '0; c_fmin <= '0; c_fmax <= '0; c_omin <= '0;
      c_omax  <= '0; c_ohw  <= '0; c_nmax <= '0; c_mmax <= '0;
      c_rev   <= 1'b0;
      n_lo <= '0; n_hi <= '0; n_cur <= '0;
      m_lo <= '0; m_hi <= '0; m_cur <= '0;
      fint_q  <= '0;
      div_go  <= 1'b0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          c_clkin <= clkin_rate; c_fmin <= fint_min; c_fmax <= fint_max;
          c_omin  <= osc_min;    c_omax <= osc_max;  c_ohw  <= osc_hw_max;
          c_nmax  <= n_limit;    c_mmax <= m_limit;  c_rev  <= reverse_order;
          found_q <= 1'b0;
          state_q <= ST_DIV_NLO;
          div_go  <= 1'b1;
        end
        ST_DIV_NLO: if (div_done) begin
          n_lo    <= (ceil_n == '0) ? FW'(1) : ceil_n;
          state_q <= ST_DIV_NHI;
          div_go  <= 1'b1;
        end
        ST_DIV_NHI: if (div_done) begin
          n_hi    <= (div_q < c_nmax) ? div_q : c_nmax;
          state_q <= ST_N_SETUP;
        end
        ST_N_SETUP: begin
          if (n_empty) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            n_cur   <= n_first;
            state_q <= ST_DIV_FINT;
            div_go  <= 1'b1;
          end
        end
        ST_DIV_FINT: if (div_done) begin
          fint_q  <= div_q;
          state_q <= ST_DIV_MLO;
          div_go  <= 1'b1;
        end
        ST_DIV_MLO: if (div_done) begin
          m_lo    <= (half_up == '0) ? FW'(1) : half_up;
          state_q <= ST_DIV_MHI;
          div_go  <= 1'b1;
        end
        ST_DIV_MHI: if (div_done) begin
          m_hi    <= (q_half < c_mmax) ? q_half : c_mmax;
          state_q <= ST_DIV_MHW;
          div_go  <= 1'b1;
        end
        ST_DIV_MHW: if (div_done) begin
          if (q_half < m_hi) m_hi <= q_half;
          state_q <= ST_M_SETUP;
        end
        ST_M_SETUP: begin
          if (!m_empty) begin
            m_cur   <= m_first;
            state_q <= ST_OFFER;
          end else if (n_next_end) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            n_cur   <= n_next;
            state_q <= ST_DIV_FINT;
            div_go  <= 1'b1;
          end
        end
        ST_OFFER: if (cand_ready) begin
          if (cand_accept) begin
            found_q <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (!m_next_end) begin
            m_cur <= m_next;
          end else if (n_next_end) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            n_cur   <= n_next;
            state_q <= ST_DIV_FINT;
            div_go  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [OW-1:0] mf_prod;
  assign mf_prod = OW'(m_cur) * OW'(fint_q);

  assign busy       = (state_q != ST_IDLE);
  assign cand_valid = (state_q == ST_OFFER);
  assign cand_n     = n_cur;
  assign cand_m     = m_cur;
  assign cand_fint  = fint_q;
  assign cand_osc   = {mf_prod[OW-2:0], 1'b0};
  assign done       = done_q;
  assign found      = found_q;
endmodule

// File: rtl/pll_div_search_chk.sv
`timescale 1ns/1ps
module pll_div_search_chk #(
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [FW-1:0] clkin_rate,
  input logic          busy,
  input logic          cand_valid,
  input logic          cand_ready,
  input logic          cand_accept,
  input logic [FW-1:0] cand_n,
  input logic [FW-1:0] cand_m,
  input logic [FW-1:0] cand_fint,
  input logic          done,
  input logic          found
);
  logic [2*FW-1:0] nf_prod;
  logic [2*FW-1:0] clk_ext;
  assign nf_prod = (2*FW)'(cand_n) * (2*FW)'(cand_fint);
  assign clk_ext = (2*FW)'(clkin_rate);

  // R7: stalled candidate holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_n) && $stable(cand_m) && $stable(cand_fint));

  // R3: fint is the truncated quotient of clkin by N
  a_r3_fint_quot: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (nf_prod <= clk_ext) && ((clk_ext - nf_prod) < (2*FW)'(cand_n)));

  // R8: found rises only after an accepting transfer
  a_r8_found_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> $past(cand_valid && cand_ready && cand_accept));

  // R8: no candidate alongside the end pulse
  a_r8_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cand_valid);

  // R9: end pulse lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: offered dividers are never zero
  a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (cand_n != '0) && (cand_m != '0));

  // R11: candidates only while busy
  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> busy);
endmodule

bind pll_div_search pll_div_search_chk #(.FW(FW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clkin_rate  (clkin_rate),
  .busy        (busy),
  .cand_valid  (cand_valid),
  .cand_ready  (cand_ready),
  .cand_accept (cand_accept),
  .cand_n      (cand_n),
  .cand_m      (cand_m),
  .cand_fint   (cand_fint),
  .done        (done),
  .found       (found)
);

// File: tb/pll_div_search_tb.sv
`timescale 1ns/1ps
module pll_div_search_tb_top;
  localparam int FW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] clkin_rate = '0, fint_min = '0, fint_max = '0;
  logic [FW-1:0] osc_min = '0, osc_max = '0, osc_hw_max = '0, n_limit = '0, m_limit = '0;
  logic          reverse_order = 1'b0;
  logic          busy, cand_valid, done, found;
  logic          cand_ready = 1'b0, cand_accept = 1'b0;
  logic [FW-1:0] cand_n, cand_m, cand_fint;
  logic [2*FW:0] cand_osc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pll_div_search #(.FW(FW)) dut_i (
    .clk (clk), .rst_n (rst_n), .start (start),
    .clkin_rate (clkin_rate), .fint_min (fint_min), .fint_max (fint_max),
    .osc_min (osc_min), .osc_max (osc_max), .osc_hw_max (osc_hw_max),
    .n_limit (n_limit), .m_limit (m_limit), .reverse_order (reverse_order),
    .busy (busy), .cand_valid (cand_valid), .cand_ready (cand_ready),
    .cand_accept (cand_accept), .cand_n (cand_n), .cand_m (cand_m),
    .cand_fint (cand_fint), .cand_osc (cand_osc), .done (done), .found (found)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input longint ck, input longint fmn, input longint fmx,
                         input longint omn, input longint omx, input longint ohw,
                         input longint nl, input longint ml, input bit rv);
    clkin_rate = FW'(ck); fint_min = FW'(fmn); fint_max = FW'(fmx);
    osc_min = FW'(omn); osc_max = FW'(omx); osc_hw_max = FW'(ohw);
    n_limit = FW'(nl); m_limit = FW'(ml); reverse_order = rv;
  endtask

  task automatic wait_evt();
    int t = 0;
    while (!cand_valid && !done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 5000) chk(1'b0, "R9 timeout waiting for candidate or done", 0, 1);
  endtask

  function automatic longint cdiv(input longint a, input longint b);
    return (a + b - 1) / b;
  endfunction

  // acc_idx < 0: reject all; poke: pulse start during a stall (R11)
  task automatic run_case(input string name, input int acc_idx, input bit poke);
    longint na, nb, ns, ne, nst, omx;
    bit     n_empty, stop, hit;
    int     k;
    $display("-- %s", name);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(found == 1'b0, "R11 found cleared by start", found, 0);
    na = cdiv(longint'(clkin_rate), longint'(fint_max)); if (na < 1) na = 1;
    nb = longint'(clkin_rate) / longint'(fint_min);
    if (nb > longint'(n_limit)) nb = longint'(n_limit);
    omx = (osc_max == '0) ? 64'h0000_0000_FFFF_FFFF : longint'(osc_max);
    if (reverse_order) begin ns = nb; ne = na; nst = -1; n_empty = (nb <= na); end
    else               begin ns = na; ne = nb; nst = 1;  n_empty = (na >= nb); end
    stop = 0; hit = 0; k = 0;
    if (!n_empty) begin
      for (longint n = ns; n != ne && !stop; n += nst) begin
        longint fi, ma, mb, ms, me, mst;
        bit     m_empty;
        fi = longint'(clkin_rate) / n;
        ma = (cdiv(longint'(osc_min), fi) + 1) / 2; if (ma < 1) ma = 1;
        mb = (omx / fi) / 2;
        if ((longint'(osc_hw_max) / fi) / 2 < mb) mb = (longint'(osc_hw_max) / fi) / 2;
        if (longint'(m_limit) < mb) mb = longint'(m_limit);
        if (reverse_order) begin ms = mb; me = ma; mst = -1; m_empty = (mb <= ma); end
        else               begin ms = ma; me = mb; mst = 1;  m_empty = (ma >= mb); end
        if (!m_empty) begin
          for (longint m = ms; m != me && !stop; m += mst) begin
            logic [2*FW:0] eosc;
            logic [FW-1:0] hn, hm;
            wait_evt();
            if (!cand_valid) begin
              chk(1'b0, "R9/R10 search ended early, candidate index", k, k + 1);
              stop = 1;
            end else begin
              eosc = (2*FW+1)'(2 * m * fi);
              chk(cand_n == FW'(n), "R2/R6 cand_n", longint'(cand_n), n);
              chk(cand_m == FW'(m), "R4/R5/R6 cand_m", longint'(cand_m), m);
              chk(cand_fint == FW'(fi) && cand_osc == eosc, "R3 fint/osc",
                  longint'(cand_fint), fi);
              hn = cand_n; hm = cand_m;
              for (int s = 0; s < k % 3; s++) begin
                if (poke && k == 1 && s == 0) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk(cand_valid && cand_n == hn && cand_m == hm, "R7/R11 held under stall",
                    longint'(cand_m), longint'(hm));
              end
              cand_ready = 1'b1;
              cand_accept = (k == acc_idx);
              @(negedge clk);
              cand_ready = 1'b0;
              cand_accept = 1'b0;
              if (k == acc_idx) begin
                chk(done && found, "R8 done with found after accept", {done, found}, 3);
                stop = 1; hit = 1;
              end
              k++;
            end
          end
        end
      end
    end
    if (hit) begin
      for (int s = 0; s < 3; s++) begin
        @(negedge clk);
        chk(!cand_valid && found && !done, "R8/R11 quiet after accept, found held",
            {cand_valid, found, done}, 2);
      end
    end else if (!stop) begin
      wait_evt();
      chk(done && !cand_valid && !found, (k == 0) ? "R10 empty range ends at once" :
          "R9 exhaustion", {done, cand_valid, found}, 4);
      chk(acc_idx < 0 || acc_idx >= k, "R9 candidate count", k, k);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cand_valid && !done && !found, "R1 reset state",
        {busy, cand_valid, done, found}, 0);

    set_cfg(1000, 150, 400, 1200, 3000, 2600, 10, 20, 0);
    run_case("forward, all rejected (R2 R4)", -1, 0);
    run_case("forward, accept fourth, start poked while busy (R8 R11)", 3, 1);
    set_cfg(1000, 150, 400, 1200, 3000, 2600, 10, 20, 1);
    run_case("reverse, all rejected (R6)", -1, 0);
    set_cfg(1000, 150, 400, 1200, 0, 5000, 4, 5, 0);
    run_case("unlimited osc_max with N and M clamps (R5)", -1, 0);
    set_cfg(1000, 500, 500, 1200, 3000, 2600, 10, 20, 0);
    run_case("empty N range (R10)", -1, 0);
    set_cfg(1000, 150, 400, 1200, 3000, 2600, 10, 1, 0);
    run_case("every M range empty (R10)", -1, 0);
    set_cfg(1000, 150, 400, 1200, 0, 5000, 10, 20, 1);
    run_case("reverse unlimited, accept first (R6 R8)", 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule